// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Controller

This block is the slave-side protocol engine of a 512-byte serial EEPROM. The storage is a synthesizable register array. The block runs on a fast system clock and oversamples the four serial pins (select, serial clock, data in, pause) and a write-protect pin. It recognises six commands: array read, array write, latch set, latch clear, status read and status write. A read streams bytes out until the host deselects the part. A write collects up to one page of bytes in a buffer. That buffer reaches the array only if the host ends the frame cleanly on a byte boundary and the protection unit grants the commit.

The serial clock idles low (SPI mode 0). Data in is taken on the rising serial clock and data out moves after the falling serial clock, most significant bit first. The system clock must run at least four times faster than the serial clock, because each pin passes through a two-flop synchronizer before its edges are detected. The data-out pin is modelled as a value plus an output enable; a deasserted enable stands for high impedance.

A commit starts a self-timed busy period of `WR_CYCLES` system clocks. During that period the status byte can still be read.

Top module: `spi_eeprom_slave`

## Requirements
- R1: The first byte of a frame is the command. Bits 7:4 must be zero, bit 3 carries address bit 8 for array reads and writes, and bits 2:0 select the command: 011 read, 010 write, 110 set latch, 100 clear latch, 101 status read, 001 status write. For the latch and status commands, bit 3 is a don't-care.
- R2: Every command, address and data byte is shifted most significant bit first. Data in is taken on the rising serial clock. Read data is presented after the falling serial clock, so the first data bit is valid before the first data-phase rising edge.
- R3: A read sends the low eight address bits after the command byte. Data then streams out, and the address increments after each byte and wraps from 1FFh to 000h.
- R4: A write takes the low eight address bits, then data bytes. The low four address bits wrap inside the 16-byte page, so a later byte overwrites an earlier byte aimed at the same column.
- R5: A write or status write commits only when select rises right after the last bit of a complete data byte. A rise at any other point discards the operation.
- R6: The status byte has bits 7:4 at zero, bit 3 and bit 2 as the two protect-level bits, bit 1 as the write-enable latch and bit 0 as write-in-progress. The latch is set by the set-latch command only when select rises after exactly eight clocks. It is cleared by the clear-latch command, by every granted commit, and while write-protect is low. A write attempted with the latch clear changes nothing.
- R7: Protect level 00 guards nothing, 01 guards 180h–1FFh, 10 guards 100h–1FFh and 11 guards the whole array. An array write that falls in a guarded range is refused. While write-protect is low, array writes and status writes are refused.
- R8: A granted commit holds write-in-progress for `WR_CYCLES` system clocks. While it is held, an array read leaves data out in high impedance, a further write is refused, and the status read still works.
- R9: Pause low while the serial clock is low pauses the sequence at once. Pause low while the serial clock is high pauses it at the next falling edge. The sequence resumes once pause is high while the serial clock is low. While paused, serial clock and data in are ignored and the sequence state is kept. While pause is low, data out is in high impedance.
- R10: Data out is in high impedance whenever select is high.
- R11: After reset, the status byte reads 00h and data out is in high impedance. No command is accepted until select has gone from high to low.
- R12: An unrecognised command byte makes the block ignore the remainder of the frame until select goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| wp_n | input | 1 | Write protect, active low |
| so | output | 1 | Serial data out value |
| so_oe | output | 1 | Data out enable; low models high impedance |

## Verification
A table of addresses is written and read back. The table covers both halves of the array, both values of the address bit carried in the command byte, and data patterns with alternating and asymmetric bits, so a swapped bit order or a dropped ninth address bit shows up as wrong data.

A page burst of eighteen bytes that starts two columns before the page end is read back as sixteen bytes. This separates in-page wrap from carrying into the next page.

Frames cut short, frames with extra clocks, and unrecognised commands are each followed by a status read. That read shows whether the latch or the array was disturbed.

Protect levels, the write-protect pin, reads during the busy period, and pauses entered with the serial clock low and high each get their own frames. Each of these frames pins down one gating condition.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int BYTE_W = 8;

  // low three command bits; bits 7:4 must be zero
  localparam logic [2:0] CMD_READ  = 3'b011;
  localparam logic [2:0] CMD_WRITE = 3'b010;
  localparam logic [2:0] CMD_WREN  = 3'b110;
  localparam logic [2:0] CMD_WRDI  = 3'b100;
  localparam logic [2:0] CMD_RDSR  = 3'b101;
  localparam logic [2:0] CMD_WRSR  = 3'b001;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_CMD, SQ_ADDR, SQ_RDDATA, SQ_WRDATA,
    SQ_SROUT, SQ_SRIN, SQ_SRDONE, SQ_LATCH, SQ_SKIP
  } seq_e;
endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
  parameter int          W       = 5,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/eep_guard.sv
module eep_guard #(
  parameter int WR_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wp_ok,
  input  logic       wren,
  input  logic       wrdi,
  input  logic       arr_req,
  input  logic [1:0] arr_top,
  input  logic       sr_req,
  input  logic [1:0] sr_bp,
  output logic       arr_grant,
  output logic       busy,
  output logic [7:0] status
);
  localparam int CW = $clog2(WR_CYCLES + 1);

  logic [CW-1:0] cnt, cnt_n;
  logic [1:0]    bp, bp_n;
  logic          wel, wel_n;
  logic          guarded, sr_grant;

  always_comb begin
    unique case (bp)
      2'b00:   guarded = 1'b0;
      2'b01:   guarded = &arr_top;
      2'b10:   guarded = arr_top[1];
      default: guarded = 1'b1;
    endcase
  end

  assign busy      = (cnt != '0);
  assign arr_grant = arr_req & wel & wp_ok & ~busy & ~guarded;
  assign sr_grant  = sr_req  & wel & wp_ok & ~busy;
  assign status    = {4'b0000, bp, wel, busy};

  always_comb begin
    cnt_n = cnt;
    bp_n  = bp;
    wel_n = wel;
    if (arr_grant || sr_grant) cnt_n = CW'(WR_CYCLES);
    else if (busy)             cnt_n = cnt - CW'(1);
    if (sr_grant) bp_n = sr_bp;
    if (!wp_ok)                      wel_n = 1'b0;
    else if (arr_grant || sr_grant)  wel_n = 1'b0;
    else if (wren)                   wel_n = 1'b1;
    else if (wrdi)                   wel_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      bp  <= 2'b00;
      wel <= 1'b0;
    end else begin
      cnt <= cnt_n;
      bp  <= bp_n;
      wel <= wel_n;
    end
  end
endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     buf_clr,
  input  logic                     buf_we,
  input  logic [PAGE_W-1:0]        buf_col,
  input  logic [7:0]               buf_din,
  input  logic                     commit,
  input  logic [ADDR_W-PAGE_W-1:0] page,
  input  logic [ADDR_W-1:0]        rd_idx,
  output logic [7:0]               rd_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;

  logic [7:0]      mem  [DEPTH];
  logic [7:0]      pbuf [PAGE];
  logic [PAGE-1:0] mask, mask_n;

  assign rd_data = mem[rd_idx];

  always_comb begin
    mask_n = mask;
    if (buf_clr)     mask_n = '0;
    else if (buf_we) mask_n[buf_col] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask <= '0;
    else        mask <= mask_n;
  end

  always_ff @(posedge clk) begin
    if (buf_we) pbuf[buf_col] <= buf_din;
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < PAGE; c++) begin
      if (commit && mask[c]) mem[{page, PAGE_W'(c)}] <= pbuf[c];
    end
  end
endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave #(
  parameter int ADDR_W    = 9,
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  input  logic wp_n,
  output logic so,
  output logic so_oe
);
  import eep_pkg::*;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  // pin order {wp, hold, si, cs, sck}; cs resets low so a true fall is needed
  logic [4:0] pins_s;
  logic sck_s, cs_s, si_s, hold_s, wp_s;
  eep_sync #(.W(5), .RST_VAL(5'b11000)) u_sync (
    .clk(clk), .rst_n(rst_sn), .d({wp_n, hold_n, si, cs_n, sck}), .q(pins_s));
  assign {wp_s, hold_s, si_s, cs_s, sck_s} = pins_s;

  logic sck_d, cs_d;
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      sck_d <= 1'b0;
      cs_d  <= 1'b0;
    end else begin
      sck_d <= sck_s;
      cs_d  <= cs_s;
    end
  end

  logic sck_rise, sck_fall, cs_rise, cs_fall;
  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;
  assign cs_rise  = cs_s & ~cs_d;
  assign cs_fall  = ~cs_s & cs_d;

  // sequencer state
  seq_e              state, state_n;
  logic [2:0]        bitcnt, bitcnt_n;
  logic [6:0]        shin, shin_n;
  logic [ADDR_W-1:0] addr, addr_n;
  logic [PAGE_W-1:0] col, col_n;
  logic [7:0]        out_sh, out_sh_n;
  logic [1:0]        sr_bp, sr_bp_n;
  logic op_rd, op_rd_n, op_set, op_set_n, wr_have, wr_have_n;
  logic so_q, so_n, drive, drive_n, mute, mute_n;
  logic active, active_n, paused, paused_n;

  logic       run, byte_done;
  logic [7:0] byte_in;
  logic       wren_p, wrdi_p, arr_req, sr_req, buf_clr, buf_we;
  logic       arr_grant, busy;
  logic [7:0] status_w, rd_data;
  logic [ADDR_W-1:0] rd_idx;

  assign run       = active & ~cs_s & hold_s & ~paused;
  assign byte_in   = {shin, si_s};
  assign byte_done = run & sck_rise & (bitcnt == 3'd7);
  assign rd_idx    = (state == SQ_ADDR) ? {addr[ADDR_W-1], byte_in}
                                        : addr + ADDR_W'(1);

  always_comb begin
    paused_n = paused;
    if (cs_s || !active)       paused_n = 1'b0;
    else if (!sck_s && !hold_s) paused_n = 1'b1;
    else if (!sck_s && hold_s)  paused_n = 1'b0;
  end

  always_comb begin
    state_n = state;   bitcnt_n = bitcnt;  shin_n  = shin;
    addr_n  = addr;    col_n    = col;     out_sh_n = out_sh;
    sr_bp_n = sr_bp;   op_rd_n  = op_rd;   op_set_n = op_set;
    wr_have_n = wr_have; so_n = so_q; drive_n = drive; mute_n = mute;
    active_n = active;
    wren_p = 1'b0; wrdi_p = 1'b0; arr_req = 1'b0; sr_req = 1'b0;
    buf_clr = 1'b0; buf_we = 1'b0;

    if (cs_fall) begin
      active_n = 1'b1;  state_n = SQ_CMD;  bitcnt_n = '0;
      drive_n  = 1'b0;  mute_n  = 1'b0;
    end else if (cs_rise) begin
      if (active) begin
        unique case (state)
          SQ_WRDATA: arr_req = (bitcnt == 3'd0) & wr_have;
          SQ_SRDONE: sr_req  = (bitcnt == 3'd0);
          SQ_LATCH:  begin wren_p = op_set; wrdi_p = ~op_set; end
          default: ;
        endcase
      end
      active_n = 1'b0;  state_n = SQ_IDLE;  drive_n = 1'b0;
    end else if (run && sck_rise) begin
      bitcnt_n = bitcnt + 3'd1;
      shin_n   = byte_in[6:0];
      if (state == SQ_LATCH || state == SQ_SRDONE) begin
        state_n = SQ_SKIP;
      end else if (bitcnt == 3'd7) begin
        unique case (state)
          SQ_CMD: begin
            if (byte_in[7:4] != 4'h0) state_n = SQ_SKIP;
            else begin
              unique case (byte_in[2:0])
                CMD_READ:  begin op_rd_n = 1'b1; addr_n[ADDR_W-1] = byte_in[3]; state_n = SQ_ADDR; end
                CMD_WRITE: begin op_rd_n = 1'b0; addr_n[ADDR_W-1] = byte_in[3]; state_n = SQ_ADDR; end
                CMD_WREN:  begin op_set_n = 1'b1; state_n = SQ_LATCH; end
                CMD_WRDI:  begin op_set_n = 1'b0; state_n = SQ_LATCH; end
                CMD_RDSR:  begin out_sh_n = status_w; state_n = SQ_SROUT; end
                CMD_WRSR:  state_n = SQ_SRIN;
                default:   state_n = SQ_SKIP;
              endcase
            end
          end
          SQ_ADDR: begin
            addr_n = {addr[ADDR_W-1], byte_in};
            if (op_rd) begin
              out_sh_n = rd_data;  mute_n = busy;  state_n = SQ_RDDATA;
            end else begin
              col_n = byte_in[PAGE_W-1:0];  buf_clr = 1'b1;
              wr_have_n = 1'b0;  state_n = SQ_WRDATA;
            end
          end
          SQ_RDDATA: begin addr_n = rd_idx; out_sh_n = rd_data; end
          SQ_WRDATA: begin buf_we = 1'b1; col_n = col + PAGE_W'(1); wr_have_n = 1'b1; end
          SQ_SROUT:  out_sh_n = status_w;
          SQ_SRIN:   begin sr_bp_n = byte_in[3:2]; state_n = SQ_SRDONE; end
          default: ;
        endcase
      end
    end else if (run && sck_fall) begin
      if (state == SQ_RDDATA || state == SQ_SROUT) begin
        so_n = out_sh[7];  out_sh_n = {out_sh[6:0], 1'b0};  drive_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state <= SQ_IDLE;  bitcnt <= '0;  shin <= '0;  addr <= '0;
      col <= '0;  out_sh <= '0;  sr_bp <= '0;  op_rd <= 1'b0;
      op_set <= 1'b0;  wr_have <= 1'b0;  so_q <= 1'b0;  drive <= 1'b0;
      mute <= 1'b0;  active <= 1'b0;  paused <= 1'b0;
    end else begin
      state <= state_n;  bitcnt <= bitcnt_n;  shin <= shin_n;  addr <= addr_n;
      col <= col_n;  out_sh <= out_sh_n;  sr_bp <= sr_bp_n;  op_rd <= op_rd_n;
      op_set <= op_set_n;  wr_have <= wr_have_n;  so_q <= so_n;  drive <= drive_n;
      mute <= mute_n;  active <= active_n;  paused <= paused_n;
    end
  end

  assign so    = so_q;
  assign so_oe = run & drive & ~mute;

  eep_guard #(.WR_CYCLES(WR_CYCLES)) u_guard (
    .clk(clk), .rst_n(rst_sn), .wp_ok(wp_s), .wren(wren_p), .wrdi(wrdi_p),
    .arr_req(arr_req), .arr_top(addr[ADDR_W-1:ADDR_W-2]),
    .sr_req(sr_req), .sr_bp(sr_bp),
    .arr_grant(arr_grant), .busy(busy), .status(status_w));

  eep_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_store (
    .clk(clk), .rst_n(rst_sn), .buf_clr(buf_clr), .buf_we(buf_we),
    .buf_col(col), .buf_din(byte_in), .commit(arr_grant),
    .page(addr[ADDR_W-1:PAGE_W]), .rd_idx(rd_idx), .rd_data(rd_data));
endmodule

// File: rtl/eep_checks.sv
module eep_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_sync,
  input logic       hold_sync,
  input logic       paused,
  input logic       so_oe,
  input logic       busy,
  input logic       cs_rise,
  input logic       wel,
  input logic [1:0] bp
);
  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cs_sync |-> !so_oe); // R10
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_sync |-> !so_oe); // R9
  AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> !so_oe); // R9
  AST_COMMIT_ON_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise)); // R5
  AST_COMMIT_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(wel) && !wel)); // R6
  AST_LEVEL_ONLY_BY_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bp) |-> $rose(busy)); // R7
endmodule

bind spi_eeprom_slave eep_checks u_chk (
  .clk(clk), .rst_n(rst_sn), .cs_sync(cs_s), .hold_sync(hold_s),
  .paused(paused), .so_oe(so_oe), .busy(busy), .cs_rise(cs_rise),
  .wel(status_w[1]), .bp(status_w[3:2]));

// File: tb/spi_eeprom_slave_tb.sv
module spi_eeprom_slave_tb;
  localparam int HALF = 6;
  localparam int NVEC = 6;
  // {address[8:0], data[7:0]}
  localparam logic [16:0] VEC [NVEC] = '{
    {9'h000, 8'hA5}, {9'h1FF, 8'hC3}, {9'h0C0, 8'hEE},
    {9'h180, 8'h6B}, {9'h055, 8'h11}, {9'h101, 8'h4D}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b0, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
  logic so, so_oe;
  int n_chk = 0, n_fail = 0, hold_bit = -1, pause_oe_hits = 0;
  bit hold_hi = 1'b0, done = 1'b0;

  always #4 clk = ~clk;

  spi_eeprom_slave u_dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck),
    .si(si), .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_oe(so_oe));

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic junk();
    wt(HALF);
    for (int k = 0; k < 2; k++) begin
      si = ~si;
      if (so_oe) pause_oe_hits++;
      sck = 1'b1; wt(HALF);
      if (so_oe) pause_oe_hits++;
      sck = 1'b0; wt(HALF);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx,
                      output bit all_oe, input int nbits = 8);
    all_oe = 1'b1; rx = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      si = tx[i];
      if (hold_bit == i && !hold_hi) begin
        hold_n = 1'b0; junk(); hold_n = 1'b1; wt(HALF); si = tx[i];
      end
      wt(HALF);
      rx[i] = so;
      if (!so_oe) all_oe = 1'b0;
      sck = 1'b1; wt(HALF);
      if (hold_bit == i && hold_hi) begin
        hold_n = 1'b0; wt(3); sck = 1'b0; junk(); hold_n = 1'b1; wt(HALF);
      end else sck = 1'b0;
    end
  endtask

  task automatic send(input logic [7:0] tx);
    logic [7:0] r; bit o;
    xfer(tx, r, o);
  endtask

  task automatic sel();   cs_n = 1'b0; wt(HALF); endtask
  task automatic desel(); wt(HALF); cs_n = 1'b1; wt(2 * HALF); endtask

  task automatic cmd1(input logic [7:0] c); sel(); send(c); desel(); endtask

  task automatic rdsr(output logic [7:0] st);
    bit o;
    sel(); send(8'h05); xfer(8'h00, st, o); desel();
  endtask

  task automatic wait_idle();
    logic [7:0] st;
    for (int k = 0; k < 100; k++) begin
      rdsr(st);
      if (!st[0]) break;
    end
  endtask

  task automatic mem_write(input logic [8:0] a, input logic [7:0] d);
    cmd1(8'h06);
    sel(); send({4'h0, a[8], 3'b010}); send(a[7:0]); send(d); desel();
    wait_idle();
  endtask

  task automatic mem_read(input logic [8:0] a, output logic [7:0] d, output bit o);
    sel(); send({4'h0, a[8], 3'b011}); send(a[7:0]); xfer(8'h00, d, o); desel();
  endtask

  task automatic wrsr(input logic [7:0] v);
    cmd1(8'h06); sel(); send(8'h01); send(v); desel(); wait_idle();
  endtask

  initial begin
    logic [7:0] st, d, exp8; bit o;

    // reset with select held low: a frame without a real select fall is ignored
    wt(3); rst_n = 1'b1; wt(4);
    chk(so_oe == 1'b0, "R11 data out idle after reset", so_oe, 0);
    send(8'h06); cs_n = 1'b1; wt(2 * HALF);
    rdsr(st);
    chk(st == 8'h00, "R11 status after reset", st, 8'h00);
    chk(so_oe == 1'b0, "R10 data out idle while deselected", so_oe, 0);

    // table walk: write then read back
    for (int v = 0; v < NVEC; v++) begin
      mem_write(VEC[v][16:8], VEC[v][7:0]);
      mem_read(VEC[v][16:8], d, o);
      chk(d == VEC[v][7:0] && o, "R1 R2 table readback", d, VEC[v][7:0]);
    end

    // sequential read wraps from 1FFh to 000h
    sel(); send(8'h0B); send(8'hFF);
    xfer(8'h00, d, o); chk(d == 8'hC3, "R3 read at 1FFh", d, 8'hC3);
    xfer(8'h00, d, o); chk(d == 8'hA5, "R3 read wraps to 000h", d, 8'hA5);
    desel();

    // latch: extra clock after set command discards it
    sel(); send(8'h06); xfer(8'h00, d, o, 1); desel();
    rdsr(st); chk(st == 8'h00, "R6 set with extra clock ignored", st, 8'h00);
    cmd1(8'h0E);
    rdsr(st); chk(st == 8'h02, "R6 latch set, bit 3 don't-care", st, 8'h02);
    cmd1(8'h04);
    rdsr(st); chk(st == 8'h00, "R6 latch cleared", st, 8'h00);

    // write with latch clear changes nothing
    sel(); send(8'h02); send(8'h55); send(8'h77); desel(); wait_idle();
    mem_read(9'h055, d, o); chk(d == 8'h11, "R6 write without latch refused", d, 8'h11);

    // unrecognised commands make the rest of the frame ignored
    sel(); send(8'h86); send(8'h06); desel();
    rdsr(st); chk(st == 8'h00, "R12 nonzero upper bits ignored", st, 8'h00);
    sel(); send(8'h07); send(8'h06); desel();
    rdsr(st); chk(st == 8'h00, "R12 unknown code ignored", st, 8'h00);

    // select rises mid-byte: discarded, latch kept
    cmd1(8'h06);
    sel(); send(8'h02); send(8'hC0); send(8'h12); xfer(8'h34, d, o, 4); desel();
    rdsr(st); chk(st == 8'h02, "R5 cut write starts nothing", st, 8'h02);
    mem_read(9'h0C0, d, o); chk(d == 8'hEE, "R5 cut write leaves array", d, 8'hEE);
    cmd1(8'h04);

    // busy period: status readable, array read muted, then data present
    cmd1(8'h06);
    sel(); send(8'h0A); send(8'h00); send(8'h5A); desel();
    mem_read(9'h100, d, o); chk(o == 1'b0, "R8 read while busy stays high-Z", o, 0);
    rdsr(st); chk(st == 8'h01, "R8 R6 busy flag set, latch cleared", st, 8'h01);
    cmd1(8'h06);
    sel(); send(8'h0A); send(8'h01); send(8'h99); desel();
    wait_idle();
    mem_read(9'h100, d, o); chk(d == 8'h5A, "R8 committed after busy", d, 8'h5A);
    mem_read(9'h101, d, o); chk(d == 8'h4D, "R8 write during busy refused", d, 8'h4D);
    cmd1(8'h04);

    // page write of 18 bytes starting at column E of page 030h
    cmd1(8'h06);
    sel(); send(8'h02); send(8'h3E);
    for (int k = 0; k < 18; k++) send(8'(8'h20 + k));
    desel(); wait_idle();
    sel(); send(8'h03); send(8'h30);
    for (int c = 0; c < 16; c++) begin
      xfer(8'h00, d, o);
      exp8 = (c == 14) ? 8'h30 : (c == 15) ? 8'h31 : 8'(8'h22 + c);
      chk(d == exp8, "R4 page wrap column", d, exp8);
    end
    desel();

    // protect levels
    wrsr(8'h04);
    rdsr(st); chk(st == 8'h04, "R7 level 01 stored", st, 8'h04);
    mem_write(9'h180, 8'h81);
    mem_read(9'h180, d, o); chk(d == 8'h6B, "R7 guarded quarter refused", d, 8'h6B);
    mem_write(9'h17F, 8'h7F);
    mem_read(9'h17F, d, o); chk(d == 8'h7F, "R7 below quarter allowed", d, 8'h7F);
    wrsr(8'h08);
    mem_write(9'h101, 8'h02);
    mem_read(9'h101, d, o); chk(d == 8'h4D, "R7 upper half refused", d, 8'h4D);
    wrsr(8'h0C);
    mem_write(9'h000, 8'h00);
    mem_read(9'h000, d, o); chk(d == 8'hA5, "R7 all guarded", d, 8'hA5);
    wrsr(8'h00);
    rdsr(st); chk(st == 8'h00, "R7 level cleared", st, 8'h00);

    // write-protect pin
    wp_n = 1'b0; wt(4);
    cmd1(8'h06);
    rdsr(st); chk(st == 8'h00, "R7 R6 latch held clear by protect pin", st, 8'h00);
    wp_n = 1'b1; wt(4);
    cmd1(8'h06); wp_n = 1'b0; wt(4);
    sel(); send(8'h02); send(8'h55); send(8'h99); desel(); wait_idle();
    wp_n = 1'b1;
    mem_read(9'h055, d, o); chk(d == 8'h11, "R7 write refused with protect low", d, 8'h11);

    // pause entered with serial clock low, during a read data byte
    hold_bit = 4; hold_hi = 1'b0;
    mem_read(9'h17F, d, o);
    hold_bit = -1;
    chk(d == 8'h7F, "R9 read resumes after pause", d, 8'h7F);
    chk(pause_oe_hits == 0, "R9 data out high-Z while paused", pause_oe_hits, 0);

    // pause entered with serial clock high, during a write address byte
    hold_bit = 2; hold_hi = 1'b1;
    cmd1(8'h06);
    sel(); send(8'h02); send(8'hA5); hold_bit = -1; send(8'h3C); desel();
    wait_idle();
    mem_read(9'h0A5, d, o); chk(d == 8'h3C, "R9 pause on clock high keeps sequence", d, 8'h3C);
    chk(so_oe == 1'b0, "R10 high-Z after frame", so_oe, 0);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule